// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a register-mapped watchdog. A down-counter (32 bits by default) is loaded from a programmable reload register and decrements either on every clock or only on cycles where an external 1 MHz tick enable is high, as a control bit selects. Software keeps the system alive by writing one exact 16-bit key value to a restart register. That write reloads the counter. A write of any other value has no effect.

When the counter takes a step while it already sits at zero, the watchdog expires. The counter reloads and keeps running. Each action enabled in the control register fires as a single-cycle pulse: an interrupt request, a reset request with an encoded reset scope, an external-signal trigger, and an alternate-boot flag that travels with the reset request. The clock divider, the shaping of the external pulse and the reset logic that consumes these requests all sit outside the block.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the reload register reads 0xFFFFFFFF, the control register reads 0, the status register reads 0xFFFFFFFF and all action outputs are low.
- R2: Byte offsets: 0x00 is status (read-only, returns the live counter), 0x04 is reload (read/write), 0x08 is restart (reads 0) and 0x0C is control (8 bits, upper bits read 0).
- R3: A write of exactly 0x00004755 to offset 0x08 loads the counter from the reload register at that clock edge. Any other value, including one with the right low 16 bits but nonzero upper bits, leaves the counter unchanged.
- R4: Control bit 0 is the run enable. While it is 0, the counter holds its value. Setting it again resumes decrementing from the held value.
- R5: Control bit 4 selects the step source: 1 steps only on cycles with the tick input high, 0 steps on every clock.
- R6: A step taken at count 0 is an expiry. The counter reloads instead of wrapping and keeps running, so with reload value N the expiry arrives on step N+1 after a restart.
- R7: On expiry, the interrupt output (control bit 2), the reset request (control bit 1) and the external trigger (control bit 3) each pulse high for exactly the cycle after the expiry edge, and only when their enable bit is set.
- R8: The reset scope output carries control bits 6:5 during a reset-request pulse: 00 is SoC, 01 is full chip, 10 is CPU only, and the unused code 11 is sent as 00. At all other times the output is 00.
- R9: The alternate-boot output pulses together with the reset request when control bit 7 is set. It never pulses without a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| tick_i | input | 1 | 1 MHz step enable |
| irq_o | output | 1 | Interrupt request pulse |
| rst_req_o | output | 1 | Reset request pulse |
| rst_scope_o | output | 2 | Reset scope, valid with rst_req_o |
| ext_trig_o | output | 1 | External-signal trigger pulse |
| boot_alt_o | output | 1 | Boot-from-secondary flag pulse |

## Verification
Any fault in the counter shows on the status read at once, and shows in the expiry cycle: a pulse that arrives a step early or late, or a status that does not equal the reload value in the pulse cycle. A fault in the key comparison or in the hold logic shows as a status value that moves when it must stay put, checked within a few cycles of the write. A wrong control decode shows in the one cycle of the expiry pulse as a missing action, an extra action or a wrong scope code. Every such error is therefore visible within reload+2 cycles of its cause.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   // Register byte offsets; software depends on these positions
   localparam int unsigned OFS_STATUS  = 'h0;
   localparam int unsigned OFS_RELOAD  = 'h4;
   localparam int unsigned OFS_RESTART = 'h8;
   localparam int unsigned OFS_CONTROL = 'hC;

   typedef enum logic [1:0] {
      SCOPE_SOC  = 2'b00,
      SCOPE_FULL = 2'b01,
      SCOPE_CPU  = 2'b10,
      SCOPE_RSVD = 2'b11
   } scope_e;

   // Control layout, MSB first: bit7 .. bit0
   typedef struct packed {
      logic   boot_alt;  // 7
      scope_e scope;     // 6:5
      logic   tick_sel;  // 4
      logic   ext_en;    // 3
      logic   irq_en;    // 2
      logic   rst_en;    // 1
      logic   run;       // 0
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   function automatic scope_e scope_map(input scope_e s);
      return (s == SCOPE_RSVD) ? SCOPE_SOC : s;
   endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 4,
   parameter int KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY = 'h4755,
   parameter bit STRICT_KEY = 1'b1,
   parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [CNT_W-1:0]  reload_o,
   output ctrl_t             ctrl_o,
   output logic              restart_o
);

   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
   localparam logic [ADDR_W-1:0] A_CONTROL = ADDR_W'(OFS_CONTROL);

   logic              wr_go;
   logic              key_hit;
   logic [CNT_W-1:0]  reload_q;
   ctrl_t             ctrl_q;

   assign wr_go = bus_sel & bus_wr;

   generate
      if (STRICT_KEY) begin : g_key_strict
         // whole word must equal the key
         assign key_hit = (bus_wdata == DATA_W'(KEY));
      end else begin : g_key_low
         // only the key-width low bits are compared
         assign key_hit = (bus_wdata[KEY_W-1:0] == KEY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_RST;
         ctrl_q   <= '0;
      end else if (wr_go) begin
         if (bus_addr == A_RELOAD)
            reload_q <= bus_wdata[CNT_W-1:0];
         if (bus_addr == A_CONTROL)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
   end

   assign restart_o = wr_go && (bus_addr == A_RESTART) && key_hit;

   always_comb begin
      unique case (bus_addr)
         A_STATUS:  bus_rdata = DATA_W'(cnt_i);
         A_RELOAD:  bus_rdata = DATA_W'(reload_q);
         A_CONTROL: bus_rdata = DATA_W'(ctrl_q);
         default:   bus_rdata = '0;
      endcase
   end

   assign reload_o = reload_q;
   assign ctrl_o   = ctrl_q;

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 32,
   parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_sel_i,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             step;
   logic             at_zero;

   assign step     = run_i & (tick_sel_i ? tick_i : 1'b1);
   assign at_zero  = (cnt_q == '0);
   // a restart in the same cycle wins over the expiry
   assign expire_o = step & at_zero & ~restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= RELOAD_RST;
      else if (restart_i)
         cnt_q <= reload_i;
      else if (step)
         cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/kwdt_actions.sv
module kwdt_actions
   import kwdt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   expire_i,
   input  ctrl_t  ctrl_i,
   output logic   irq_o,
   output logic   rst_req_o,
   output scope_e scope_o,
   output logic   ext_o,
   output logic   boot_o
);

   logic fire_rst;

   assign fire_rst = expire_i & ctrl_i.rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         rst_req_o <= 1'b0;
         scope_o   <= SCOPE_SOC;
         ext_o     <= 1'b0;
         boot_o    <= 1'b0;
      end else begin
         irq_o     <= expire_i & ctrl_i.irq_en;
         ext_o     <= expire_i & ctrl_i.ext_en;
         rst_req_o <= fire_rst;
         boot_o    <= fire_rst & ctrl_i.boot_alt;
         scope_o   <= fire_rst ? scope_map(ctrl_i.scope) : SCOPE_SOC;
      end
   end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 4,
   parameter int KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY = 'h4755,
   parameter bit STRICT_KEY = 1'b1,
   parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_i,
   output logic              irq_o,
   output logic              rst_req_o,
   output logic [1:0]        rst_scope_o,
   output logic              ext_trig_o,
   output logic              boot_alt_o
);

   initial begin : g_param_chk
      assert (CNT_W >= 2 && CNT_W <= DATA_W)
         else $fatal(1, "kwdt_top: CNT_W must lie in 2..DATA_W");
      assert (KEY_W >= 1 && KEY_W <= DATA_W)
         else $fatal(1, "kwdt_top: KEY_W must lie in 1..DATA_W");
      assert (DATA_W >= int'(CTRL_W))
         else $fatal(1, "kwdt_top: DATA_W too narrow for control");
      assert (ADDR_W >= 4)
         else $fatal(1, "kwdt_top: ADDR_W must cover offset 0xC");
   end

   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] reload_w;
   ctrl_t            ctrl_w;
   logic             restart_w;
   logic             expire_w;
   scope_e           scope_w;

   kwdt_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W),
      .KEY(KEY), .STRICT_KEY(STRICT_KEY), .RELOAD_RST(RELOAD_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_i(cnt_w), .reload_o(reload_w), .ctrl_o(ctrl_w),
      .restart_o(restart_w)
   );

   kwdt_counter #(
      .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)
   ) u_counter (
      .clk(clk), .rst_n(rst_n),
      .run_i(ctrl_w.run), .tick_sel_i(ctrl_w.tick_sel), .tick_i(tick_i),
      .restart_i(restart_w), .reload_i(reload_w),
      .cnt_o(cnt_w), .expire_o(expire_w)
   );

   kwdt_actions u_actions (
      .clk(clk), .rst_n(rst_n),
      .expire_i(expire_w), .ctrl_i(ctrl_w),
      .irq_o(irq_o), .rst_req_o(rst_req_o), .scope_o(scope_w),
      .ext_o(ext_trig_o), .boot_o(boot_alt_o)
   );

   assign rst_scope_o = scope_w;

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 4,
   parameter int KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY = 'h4755
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  reload,
   input logic [7:0]        ctrl,
   input logic              irq_o,
   input logic              rst_req_o,
   input logic [1:0]        rst_scope_o,
   input logic              ext_trig_o,
   input logic              boot_alt_o
);

   logic key_wr;
   assign key_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'('h8))
                   && (bus_wdata == DATA_W'(KEY));

   p_key_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> (cnt == $past(reload)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[0] && !key_wr) |=> (cnt == $past(cnt)));

   p_expire_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(cnt) == '0));

   p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(ctrl[2]));

   p_ext_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_trig_o |-> $past(ctrl[3]));

   p_scope_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_req_o |-> (rst_scope_o == 2'b00));

   p_scope_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_scope_o != 2'b11);

   p_boot_with_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_alt_o |-> rst_req_o);

endmodule

bind kwdt_top kwdt_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY(KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .cnt(cnt_w), .reload(reload_w), .ctrl(ctrl_w),
   .irq_o(irq_o), .rst_req_o(rst_req_o), .rst_scope_o(rst_scope_o),
   .ext_trig_o(ext_trig_o), .boot_alt_o(boot_alt_o)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_i = 1'b0;
   logic        irq_o, rst_req_o, ext_trig_o, boot_alt_o;
   logic [1:0]  rst_scope_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   kwdt_top i_kwdt_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_i(tick_i), .irq_o(irq_o), .rst_req_o(rst_req_o),
      .rst_scope_o(rst_scope_o), .ext_trig_o(ext_trig_o),
      .boot_alt_o(boot_alt_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = 4'h0;
   endtask

   function automatic logic [4:0] outs();
      return {irq_o, rst_req_o, ext_trig_o, boot_alt_o, |rst_scope_o};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(4'h4, v); check("R1", "reload after reset", v, 32'hFFFF_FFFF);
      rd(4'hC, v); check("R1", "control after reset", v, 32'h0);
      rd(4'h0, v); check("R1", "status after reset", v, 32'hFFFF_FFFF);
      check("R1", "outputs after reset", 32'(outs()), 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(4'h4, 32'h1234_5678);
      rd(4'h4, v); check("R2", "reload readback", v, 32'h1234_5678);
      wr(4'hC, 32'hFFFF_FF00);
      rd(4'hC, v); check("R2", "control upper bits", v, 32'h0);
      rd(4'h8, v); check("R2", "restart reads zero", v, 32'h0);
      wr(4'h0, 32'h0000_0005);
      rd(4'h0, v); check("R2", "status read-only", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_key();
      logic [31:0] v;
      wr(4'h4, 32'd77);
      wr(4'h8, 32'h0000_4756);
      rd(4'h0, v); check("R3", "wrong key ignored", v, 32'hFFFF_FFFF);
      wr(4'h8, 32'h0001_4755);
      rd(4'h0, v); check("R3", "upper bits spoil key", v, 32'hFFFF_FFFF);
      wr(4'h8, 32'h0000_4755);
      rd(4'h0, v); check("R3", "exact key reloads", v, 32'd77);
   endtask

   task automatic t_hold();
      logic [31:0] s1, s2;
      wr(4'h4, 32'd100);
      wr(4'h8, 32'h4755);
      wr(4'hC, 32'h01);
      repeat (10) @(negedge clk);
      wr(4'hC, 32'h00);
      rd(4'h0, s1);
      repeat (5) @(negedge clk);
      rd(4'h0, s2); check("R4", "held while disabled", s2, s1);
      wr(4'hC, 32'h01);
      repeat (3) @(negedge clk);
      rd(4'h0, s2); check("R4", "resume from held value", s2, s1 - 32'd3);
      wr(4'hC, 32'h00);
   endtask

   task automatic t_tick();
      logic [31:0] v;
      wr(4'h4, 32'd10);
      wr(4'h8, 32'h4755);
      wr(4'hC, 32'h11);
      repeat (5) @(negedge clk);
      rd(4'h0, v); check("R5", "no tick no step", v, 32'd10);
      for (int i = 0; i < 3; i++) begin
         tick_i = 1'b1; @(negedge clk);
         tick_i = 1'b0; @(negedge clk);
      end
      rd(4'h0, v); check("R5", "one step per tick", v, 32'd7);
      wr(4'hC, 32'h00);
   endtask

   // Run one expiry with reload n and control c, checking the pulse cycle
   task automatic t_expire(input string req, input logic [7:0] c,
                           input int unsigned n);
      logic [4:0]  early = '0;
      logic [31:0] v;
      logic        r_en;
      logic [1:0]  sc;
      wr(4'hC, 32'h00);
      wr(4'h4, 32'(n));
      wr(4'h8, 32'h4755);
      wr(4'hC, 32'(c));
      for (int k = 1; k <= int'(n); k++) begin
         @(negedge clk);
         early |= outs();
      end
      @(negedge clk);
      check(req, "no action before expiry", 32'(early), 32'h0);
      r_en = c[1];
      sc   = (c[6:5] == 2'b11) ? 2'b00 : c[6:5];
      check(req, "irq pulse", 32'(irq_o), 32'(c[2]));
      check(req, "reset request pulse", 32'(rst_req_o), 32'(r_en));
      check(req, "ext trigger pulse", 32'(ext_trig_o), 32'(c[3]));
      check(req, "boot flag", 32'(boot_alt_o), 32'(r_en & c[7]));
      check(req, "reset scope", 32'(rst_scope_o), r_en ? 32'(sc) : 32'h0);
      rd(4'h0, v); check("R6", "reloaded at expiry", v, 32'(n));
      @(negedge clk);
      check("R7", "pulse lasts one cycle", 32'(outs()), 32'h0);
      wr(4'hC, 32'h00);
   endtask

   task automatic t_period();
      int cnt = 0;
      wr(4'h4, 32'd4);
      wr(4'h8, 32'h4755);
      wr(4'hC, 32'h05);
      for (int k = 0; k < 5; k++) @(negedge clk);
      check("R6", "first expiry on step 5", 32'(irq_o), 32'h1);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         cnt++;
         if (irq_o) break;
      end
      check("R6", "keeps running, period 5", 32'(cnt), 32'd5);
      wr(4'hC, 32'h00);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_key();
      t_hold();
      t_tick();
      t_expire("R7", 8'h2F, 5);   // run, reset, irq, ext, full chip
      t_expire("R8", 8'h43, 3);   // CPU scope
      t_expire("R8", 8'h63, 3);   // code 11 sent as 00
      t_expire("R9", 8'h83, 2);   // boot with reset
      t_expire("R9", 8'h85, 2);   // boot bit without reset enable
      t_expire("R7", 8'h01, 3);   // no actions enabled
      t_period();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule